// File: doc/BRIEF.md
# Two-Wire Slave Command Interface

This block is the bus-facing front end of a small register device that sits on a two-wire serial bus. It oversamples the clock and data lines with the system clock, recognises bus framing conditions, checks the first byte of every transfer against a fixed four-bit device identifier combined with four strap inputs, and acknowledges by driving an open-drain enable for the data line. After a matching address it takes an instruction byte whose upper nibble is an opcode, and the opcode decides how long the command is. Writes carry one data byte, reads return one byte per master acknowledge, and register-transfer commands consist of the instruction alone.

Each decoded command goes to a register controller as a one-cycle pulse with a kind code, the instruction byte and, for writes, the data byte. The controller supplies the byte to return for reads. While the controller reports a non-volatile programming cycle, the block does not acknowledge its own address. A master can therefore poll with address-only transfers until the device answers again.

Top module: `twcs_top`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe_o` is 0 and no command pulse is issued until a complete command has been received.
- R2: A falling data line while the clock is high (START) abandons any transfer in progress, including a partly shifted byte, and restarts address reception. A rising data line while the clock is high (STOP) releases the line and returns the block to idle.
- R3: The first byte after START is taken MSB first. If its bits 7:4 equal 4'b0101 and its bits 3:0 equal `strap_i`, the block pulls the line low for the whole ninth clock of that byte.
- R4: If the address byte does not match, the block gives no acknowledge, issues no command and leaves the line released until the next START.
- R5: While `busy_i` is 1 at the end of the address byte, the block does not acknowledge its own address. A later transfer made after `busy_i` has returned to 0 is acknowledged.
- R6: The instruction byte (second byte) is always acknowledged. Opcodes 4'b1001 and 4'b1011 in bits 7:4 are reads: a pulse with `cmd_kind_o`=2 and the instruction on `cmd_instr_o` is issued when the instruction byte is complete.
- R7: In a read, the block sends `rd_data_i` MSB first and releases the line during the ninth clock. If the master pulls the line low in that clock, the same register byte is sent again. If the master leaves it high, the block stays off the line until STOP or START.
- R8: Opcodes 4'b1010 and 4'b1100 are writes: the third byte is acknowledged, and a pulse with `cmd_kind_o`=1, the instruction and that byte on `cmd_data_o` is issued when that byte is complete.
- R9: Every other opcode is a two-byte command. Later bytes are not acknowledged, and a pulse with `cmd_kind_o`=0 and the instruction is issued only on the STOP that ends the transfer. A START before that STOP cancels the command.
- R10: `cmd_valid_o` is never high for two consecutive cycles.
- R11: `sda_oe_o` changes only after a falling edge of the clock line has been seen, or at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 4 | Low address nibble from strap pins |
| busy_i | input | 1 | Controller is in a programming cycle |
| rd_data_i | input | 8 | Byte returned for read commands |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_kind_o | output | 2 | 0 two-byte, 1 write, 2 read |
| cmd_instr_o | output | 8 | Instruction byte of the command |
| cmd_data_o | output | 8 | Data byte of a write command |

## Verification
The assertions assume that the bus clock's high and low phases each last several system clocks, longer than the synchroniser delay plus one register. They also assume that the master changes the data line only while the clock is low, except to form START and STOP. The bench drives every bus phase for ten system clocks and builds all transfers from tasks that keep to these rules. Because of this, a bit or a framing condition is never seen mid-change. The controller inputs `rd_data_i` and `busy_i` change only while the bus is idle.

// File: rtl/twcs_pkg.sv
package twcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ, S_HOLD, S_IGNORE
  } twcs_state_e;

  localparam logic [1:0] KIND_XFER  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_READ  = 2'd2;
endpackage

// File: rtl/twcs_sync.sv
module twcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/twcs_linemon.sv
module twcs_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s, sda_s, scl_q, sda_q;

  twcs_sync #(.STAGES(STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  twcs_sync #(.STAGES(STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_now   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twcs_decode.sv
module twcs_decode (
  input  logic [3:0] opcode,
  output logic       is_read,
  output logic       is_write
);
  always_comb begin
    is_read  = 1'b0;
    is_write = 1'b0;
    case (opcode)
      4'b1001, 4'b1011: is_read  = 1'b1;
      4'b1010, 4'b1100: is_write = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/twcs_top.sv
module twcs_top
  import twcs_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          BYTE_W      = 8,
  parameter logic [3:0]  DEV_ID      = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [3:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_kind_o,
  output logic [BYTE_W-1:0] cmd_instr_o,
  output logic [BYTE_W-1:0] cmd_data_o
);
  localparam int CNT_W    = $clog2(BYTE_W + 2);
  localparam int IDX_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(BYTE_W + 1);

  logic sda_now, scl_rise, scl_fall, start_det, stop_det;
  logic is_read, is_write, addr_hit, active;

  twcs_state_e       state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d, instr_q, instr_d, data_q, data_d;
  logic              oe_q, oe_d, mack_q, mack_d, valid_q, valid_d;
  logic [1:0]        kind_q, kind_d;

  twcs_linemon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twcs_decode u_dec (.opcode(rx_q[BYTE_W-1 -: 4]), .is_read(is_read), .is_write(is_write));

  assign addr_hit = (rx_q == {DEV_ID, strap_i}) && !busy_i;
  assign active   = (state_q == S_ADDR) || (state_q == S_INSTR) ||
                    (state_q == S_DATA) || (state_q == S_READ);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    instr_d  = instr_q;
    data_d   = data_q;
    oe_d     = oe_q;
    mack_d   = mack_q;
    kind_d   = kind_q;
    valid_d  = 1'b0;
    if (start_det) begin
      state_d  = S_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      if (state_q == S_HOLD) begin
        valid_d = 1'b1;
        kind_d  = KIND_XFER;
      end
      state_d = S_IDLE;
      oe_d    = 1'b0;
    end else if (active && scl_rise) begin
      if (bitcnt_q < ACK_CNT) rx_d = {rx_q[BYTE_W-2:0], sda_now};
      if (state_q == S_READ && bitcnt_q == ACK_CNT) mack_d = ~sda_now;
      bitcnt_d = bitcnt_q + 1'b1;
    end else if (active && scl_fall) begin
      if (bitcnt_q == ACK_CNT) begin
        case (state_q)
          S_ADDR: begin
            if (addr_hit) oe_d = 1'b1;
            else          state_d = S_IGNORE;
          end
          S_INSTR: begin
            oe_d    = 1'b1;
            instr_d = rx_q;
            if (is_read) begin
              valid_d = 1'b1;
              kind_d  = KIND_READ;
            end
          end
          S_DATA: begin
            oe_d    = 1'b1;
            data_d  = rx_q;
            valid_d = 1'b1;
            kind_d  = KIND_WRITE;
          end
          default: oe_d = 1'b0;
        endcase
      end else if (bitcnt_q == DONE_CNT) begin
        bitcnt_d = '0;
        oe_d     = 1'b0;
        case (state_q)
          S_ADDR:  state_d = S_INSTR;
          S_INSTR: begin
            if (is_read) begin
              state_d = S_READ;
              tx_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
            end else if (is_write) begin
              state_d = S_DATA;
            end else begin
              state_d = S_HOLD;
            end
          end
          S_READ: begin
            if (mack_q) begin
              tx_d = rd_data_i;
              oe_d = ~rd_data_i[BYTE_W-1];
            end else begin
              state_d = S_IGNORE;
            end
          end
          default: state_d = S_IGNORE;
        endcase
      end else if (state_q == S_READ && bitcnt_q != '0) begin
        oe_d = ~tx_q[IDX_W'(BYTE_W-1) - bitcnt_q[IDX_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      instr_q  <= '0;
      data_q   <= '0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b0;
      kind_q   <= KIND_XFER;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      instr_q  <= instr_d;
      data_q   <= data_d;
      oe_q     <= oe_d;
      mack_q   <= mack_d;
      kind_q   <= kind_d;
      valid_q  <= valid_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign cmd_valid_o = valid_q;
  assign cmd_kind_o  = kind_q;
  assign cmd_instr_o = instr_q;
  assign cmd_data_o  = data_q;

  // R11: the line driver moves only on a seen clock fall or framing event
  a_r11_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R5: no address acknowledge while programming
  a_r5_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR && scl_fall && !start_det && !stop_det &&
     bitcnt_q == ACK_CNT && busy_i) |=> !oe_q);

  // R4 / R9: released while ignoring, idle or holding a two-byte command
  a_r4_silent_when_passive: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IGNORE || state_q == S_IDLE || state_q == S_HOLD) |-> !oe_q);

  // R10: single-cycle command strobe
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R2: START restarts address reception with the line released
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == S_ADDR && bitcnt_q == '0 && !oe_q));
endmodule

// File: tb/twcs_top_tb.sv
`timescale 1ns/1ps
module twcs_top_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'h0;
  logic busy = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, cmd_valid;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_instr, cmd_data;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int cmd_cnt = 0;
  int dbl_pulse = 0;
  int oe_viol = 0;
  logic [1:0] last_kind = 2'd3;
  logic [7:0] last_instr = 8'h00, last_data = 8'h00;
  logic prev_valid = 1'b0, prev_oe = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twcs_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind),
    .cmd_instr_o(cmd_instr), .cmd_data_o(cmd_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        cmd_cnt++;
        last_kind  = cmd_kind;
        last_instr = cmd_instr;
        last_data  = cmd_data;
        if (prev_valid) dbl_pulse++;
      end
      if (sda_oe != prev_oe && scl_m) oe_viol++;
    end
    prev_valid = cmd_valid;
    prev_oe    = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    sda_m = b; wq(1);
    scl_m = 1'b1; wq(1);
    seen = sda_line; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], seen);
      chk(seen == b[i], "R11 slave off line during master bits", seen, b[i]);
    end
    send_bit(1'b1, seen);
    acked = ~seen;
    sda_m = 1'b1;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, seen);
      b[i] = seen;
    end
    send_bit(~mack, seen);
    sda_m = 1'b1;
  endtask

  function automatic logic [1:0] exp_kind(input logic [7:0] ins);
    case (ins[7:4])
      4'b1001, 4'b1011: return 2'd2;
      4'b1010, 4'b1100: return 2'd1;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] my_addr();
    return {4'b0101, strap};
  endfunction

  task automatic do_write(input logic [7:0] ins, input logic [7:0] dat);
    logic a; int c0;
    c0 = cmd_cnt;
    bus_start();
    send_byte(my_addr(), a); chk(a, "R3 address ack", a, 1);
    send_byte(ins, a);       chk(a, "R6 instruction ack", a, 1);
    send_byte(dat, a);       chk(a, "R8 data ack", a, 1);
    chk(cmd_cnt == c0 + 1, "R8 one write command", cmd_cnt - c0, 1);
    chk(last_kind == 2'd1 && last_instr == ins && last_data == dat, "R8 write fields",
        {last_kind, last_instr, last_data}, {2'd1, ins, dat});
    bus_stop();
    chk(cmd_cnt == c0 + 1, "R8 stop adds nothing", cmd_cnt - c0, 1);
  endtask

  task automatic do_read(input logic [7:0] ins, input logic [7:0] val);
    logic a; int c0; logic [7:0] b;
    c0 = cmd_cnt;
    rd_data = val;
    bus_start();
    send_byte(my_addr(), a); chk(a, "R3 address ack", a, 1);
    send_byte(ins, a);       chk(a, "R6 instruction ack", a, 1);
    chk(cmd_cnt == c0 + 1 && last_kind == 2'd2 && last_instr == ins, "R6 read command",
        {last_kind, last_instr}, {2'd2, ins});
    recv_byte(1'b1, b); chk(b == val, "R7 first read byte", b, val);
    recv_byte(1'b0, b); chk(b == val, "R7 repeated read byte", b, val);
    recv_byte(1'b1, b); chk(b == 8'hFF, "R7 silent after master nack", b, 8'hFF);
    bus_stop();
    chk(cmd_cnt == c0 + 1, "R7 no extra command", cmd_cnt - c0, 1);
  endtask

  task automatic do_xfer(input logic [7:0] ins, input logic [7:0] extra);
    logic a; int c0;
    c0 = cmd_cnt;
    bus_start();
    send_byte(my_addr(), a); chk(a, "R3 address ack", a, 1);
    send_byte(ins, a);       chk(a, "R6 instruction ack", a, 1);
    send_byte(extra, a);     chk(!a, "R9 extra byte not acked", a, 0);
    chk(cmd_cnt == c0, "R9 no command before stop", cmd_cnt - c0, 0);
    bus_stop();
    chk(cmd_cnt == c0 + 1 && last_kind == 2'd0 && last_instr == ins, "R9 command at stop",
        {last_kind, last_instr}, {2'd0, ins});
  endtask

  task automatic do_bad(input logic [7:0] adr);
    logic a; int c0;
    c0 = cmd_cnt;
    bus_start();
    send_byte(adr, a);   chk(!a, "R4 foreign address not acked", a, 0);
    send_byte(8'hA0, a); chk(!a, "R4 later byte not acked", a, 0);
    send_byte(8'h3C, a); chk(!a, "R4 still silent", a, 0);
    bus_stop();
    chk(cmd_cnt == c0, "R4 no command", cmd_cnt - c0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a; logic seen; int c0;
    logic [3:0] xops [4];
    xops[0] = 4'hD; xops[1] = 4'hE; xops[2] = 4'h1; xops[3] = 4'h8;
    void'($urandom(32'h5EED_0042));
    strap = 4'($urandom);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq(2);
    chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);
    chk(cmd_cnt == 0, "R1 no command after reset", cmd_cnt, 0);

    do_write(8'hA5, 8'h3F);
    do_write(8'hC7, 8'h00);
    do_read(8'h94, 8'hC3);
    do_read(8'hBB, 8'h01);
    do_xfer(8'hD6, 8'hFF);
    do_xfer(8'h22, 8'h00);
    do_bad({4'b0110, strap});
    do_bad({4'b0101, strap ^ 4'b1000});

    busy = 1'b1;
    bus_start();
    send_byte(my_addr(), a); chk(!a, "R5 no ack while busy", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(my_addr(), a); chk(a, "R5 ack once programming done", a, 1);
    bus_stop();

    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0, seen);
    bus_start();
    send_byte(my_addr(), a); chk(a, "R2 restart mid byte then ack", a, 1);
    bus_stop();

    c0 = cmd_cnt;
    bus_start();
    send_byte(my_addr(), a);
    send_byte(8'hE1, a);
    bus_start();
    send_byte(my_addr(), a); chk(a, "R2 repeated start ack", a, 1);
    bus_stop();
    chk(cmd_cnt == c0, "R9 start cancels two-byte command", cmd_cnt - c0, 0);

    for (int t = 0; t < 24; t++) begin
      logic [7:0] ins;
      case ($urandom % 4)
        0: begin
          ins = {(($urandom % 2) != 0) ? 4'hA : 4'hC, 4'($urandom)};
          chk(exp_kind(ins) == 2'd1, "R8 random opcode class", exp_kind(ins), 1);
          do_write(ins, 8'($urandom));
        end
        1: begin
          ins = {(($urandom % 2) != 0) ? 4'h9 : 4'hB, 4'($urandom)};
          do_read(ins, 8'($urandom));
        end
        2: begin
          ins = {xops[$urandom % 4], 4'($urandom)};
          do_xfer(ins, 8'($urandom));
        end
        default: do_bad({4'b0101, strap ^ 4'(1 + ($urandom % 15))});
      endcase
    end

    chk(dbl_pulse == 0, "R10 single-cycle command pulses", dbl_pulse, 0);
    chk(oe_viol == 0, "R11 driver moves only while clock low", oe_viol, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule